// File: doc/BRIEF.md
# External Data Access Router

This block takes the external-data access port of an 8-bit microcontroller core and steers each access to one of several targets: a 256-byte data SRAM inside the block, an external address/data bus, a read-only security status byte, or nowhere. The choice depends on the 16-bit access address and a 2-bit map mode held in a special-function register. The core writes that register at run time, and each new access uses the mode that is in force when the access is accepted.

The block also sets how long each access lasts. An internal SRAM access, a status read or a blocked access always takes two cycles. An access on the external bus takes two cycles plus a 3-bit stretch count, which lets slow memory-mapped peripherals sit on the bus without glue logic. A single `done` pulse marks the last cycle of every access, and read data is valid in that cycle.

Top module: `xdata_router`

## Requirements
- R1: After reset the map mode is 00, the stretch count is 0, and `busy`, `done`, `ext_strobe` and `rd_data` are all low.
- R2: In mode 00 every address from 0000h to FFFFh, including 0000h–00FFh, goes to the external bus. The read data is the value on `ext_rdata` during the `done` cycle.
- R3: In mode 01, addresses 0000h–00FFh go to the internal SRAM with no external strobe, and a read returns the last byte written there. Addresses 0100h–FFFFh go to the external bus.
- R4: Mode 10 is reserved and behaves like mode 00: every address goes to the external bus, and the internal SRAM is not touched.
- R5: In mode 11, addresses 0000h–00FFh go to the internal SRAM and 0100h–FFFBh go to the external bus, FFFBh included.
- R6: In mode 11, a read of FFFCh returns `{5'b0, lock_bits}` without an external strobe. `lock_bits` is sampled in the cycle in which the access is accepted.
- R7: In mode 11, a write to FFFCh and any access to FFFDh–FFFFh produce no external strobe. Such reads return 00h.
- R8: An internal, status or blocked access keeps `busy` high for exactly 2 cycles after acceptance, with `done` high in the second cycle only.
- R9: An external access lasts 2 + stretch cycles. `ext_strobe` and `ext_addr` are held steady for all of those cycles, and `done` is high in the last one.
- R10: A write on the register port to `MODE_ADDR` (bits 1:0) or `STRETCH_ADDR` (bits 2:0) affects only accesses accepted after it. Writes to any other register address have no effect.
- R11: The SRAM keeps its contents while mapped out. Data written in mode 01 reads back unchanged after a stretch of time in mode 00.
- R12: `rd_data` is 00h in every cycle where `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Special-function register write strobe |
| cfg_addr | input | 8 | Special-function register address |
| cfg_wdata | input | 8 | Special-function register write data |
| req_valid | input | 1 | Access request, accepted when `busy` is low |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | An access is in progress |
| done | output | 1 | Last cycle of the current access |
| rd_data | output | 8 | Read result, valid with `done` |
| lock_bits | input | 3 | Programmed state of the three lock bits |
| ext_strobe | output | 1 | External bus cycle active |
| ext_we | output | 1 | External write |
| ext_addr | output | 16 | External address |
| ext_wdata | output | 8 | External write data |
| ext_rdata | input | 8 | External read data |

## Verification
The bench builds the block with its default parameters: register addresses C4h and C5h, a 256-byte SRAM and a 3-bit stretch. With these values the full external length range, from 2 cycles up to 9, can be measured directly. Every mode boundary can also be reached by an address in the test: 00FFh/0100h, FFFBh, FFFCh and FFFFh. The external bus model answers each read with a value derived from the address, so a read that went to the wrong target shows up in the returned data. One register write is issued while an access is in flight, to show that the mode in force when the access was accepted still governs its routing.

// File: rtl/xdata_router.sv
module xdata_router #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int RAM_DEPTH = 256,
  parameter int SW = 3,
  parameter int LW = 3,
  parameter int INT_CYCLES = 2,
  parameter logic [7:0] MODE_ADDR = 8'hC4,
  parameter logic [7:0] STRETCH_ADDR = 8'hC5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_addr,
  input  logic [7:0]    cfg_wdata,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data,
  input  logic [LW-1:0] lock_bits,
  output logic          ext_strobe,
  output logic          ext_we,
  output logic [AW-1:0] ext_addr,
  output logic [DW-1:0] ext_wdata,
  input  logic [DW-1:0] ext_rdata
);
  localparam int RAW = $clog2(RAM_DEPTH);
  localparam int MAXLEN = INT_CYCLES + (1 << SW) - 1;
  localparam int CW = $clog2(MAXLEN);
  localparam logic [AW-1:0] STAT_ADDR = {AW{1'b1}} - AW'(3);

  typedef enum logic [1:0] {TGT_EXT, TGT_RAM, TGT_STAT, TGT_NONE} tgt_t;

  logic [1:0]    mode_q;
  logic [SW-1:0] stretch_q;
  logic [DW-1:0] mem [RAM_DEPTH];
  logic          active;
  logic [CW-1:0] cnt;
  tgt_t          tgt_q, tgt_d;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, hold_q;
  logic          accept;
  logic          in_low;
  logic [CW-1:0] len_m1;

  assign accept = req_valid && !active;
  assign in_low = req_addr < AW'(RAM_DEPTH);

  always_comb begin
    tgt_d = TGT_EXT;
    unique case (mode_q)
      2'b01: tgt_d = in_low ? TGT_RAM : TGT_EXT;
      2'b11: begin
        if (in_low)                      tgt_d = TGT_RAM;
        else if (req_addr == STAT_ADDR)  tgt_d = req_we ? TGT_NONE : TGT_STAT;
        else if (req_addr > STAT_ADDR)   tgt_d = TGT_NONE;
        else                             tgt_d = TGT_EXT;
      end
      default: tgt_d = TGT_EXT;
    endcase
  end

  assign len_m1 = (tgt_d == TGT_EXT) ? CW'(INT_CYCLES - 1) + CW'(stretch_q)
                                     : CW'(INT_CYCLES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= 2'b00;
      stretch_q <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == MODE_ADDR)    mode_q    <= cfg_wdata[1:0];
      if (cfg_addr == STRETCH_ADDR) stretch_q <= cfg_wdata[SW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cnt     <= '0;
      tgt_q   <= TGT_NONE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      hold_q  <= '0;
    end else if (accept) begin
      active  <= 1'b1;
      cnt     <= len_m1;
      tgt_q   <= tgt_d;
      we_q    <= req_we;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      case (tgt_d)
        TGT_RAM:  hold_q <= mem[req_addr[RAW-1:0]];
        TGT_STAT: hold_q <= DW'(lock_bits);
        default:  hold_q <= '0;
      endcase
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept && tgt_d == TGT_RAM && req_we)
      mem[req_addr[RAW-1:0]] <= req_wdata;
  end

  assign busy       = active;
  assign done       = active && cnt == '0;
  assign ext_strobe = active && tgt_q == TGT_EXT;
  assign ext_we     = ext_strobe && we_q;
  assign ext_addr   = ext_strobe ? addr_q : '0;
  assign ext_wdata  = ext_we ? wdata_q : '0;
  assign rd_data    = !done || we_q ? '0 :
                      (tgt_q == TGT_EXT) ? ext_rdata : hold_q;
endmodule

module xdata_router_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] rd_data,
  input logic          ext_strobe,
  input logic [AW-1:0] ext_addr
);
  a_r8_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ext_strobe |-> busy);
  a_r9_strobe_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_strobe && !done) |=> (ext_strobe && $stable(ext_addr)));
  a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);
  a_r12_rd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> rd_data == '0);
endmodule

bind xdata_router xdata_router_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .rd_data(rd_data), .ext_strobe(ext_strobe), .ext_addr(ext_addr)
);

// File: tb/test_xdata_router.sv
module test_xdata_router;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0, cfg_wdata = '0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic busy, done, ext_strobe, ext_we;
  logic [7:0] rd_data, ext_wdata, ext_rdata;
  logic [15:0] ext_addr;
  logic [2:0] lock_bits = 3'b000;
  int total = 0, bad = 0;
  logic swap_en = 1'b0;
  logic [2:0] swap_val = '0;

  always #10 clk = ~clk;
  assign ext_rdata = ext_strobe ? (ext_addr[7:0] ^ 8'hA5) : 8'h00;

  xdata_router i_xdata_router (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .lock_bits(lock_bits), .ext_strobe(ext_strobe),
    .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_rdata(ext_rdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic we, input logic [15:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output int cyc,
                        output int strobes, output int steady);
    logic [15:0] first_addr;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (swap_en) lock_bits = swap_val;
    cyc = 1; strobes = 0; steady = 1; first_addr = ext_addr;
    while (!done && cyc < 40) begin
      if (ext_strobe) strobes++;
      if (ext_addr !== first_addr) steady = 0;
      @(negedge clk);
      cyc++;
    end
    if (ext_strobe) strobes++;
    if (ext_addr !== first_addr) steady = 0;
    rd = rd_data;
    if (cyc >= 40) begin
      total++; bad++;
      $display("FAIL watchdog access actual=hung expected=done");
    end
    @(negedge clk);
    check("R12 rd_data idle", rd_data, 8'h00);
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 strobe", ext_strobe, 0);
    check("R1 rd_data", rd_data, 0);
  endtask

  task automatic t_mode00();
    logic [7:0] rd; int c, s, st;
    access(0, 16'h0012, 0, rd, c, s, st);
    check("R2 low addr external data", rd, 8'h12 ^ 8'hA5);
    check("R2 low addr strobe", s, 2);
    check("R1 stretch 0 length", c, 2);
    access(0, 16'hFFFC, 0, rd, c, s, st);
    check("R2 FFFC external", rd, 8'hFC ^ 8'hA5);
    check("R2 FFFC strobe", s, 2);
  endtask

  task automatic t_mode01();
    logic [7:0] rd; int c, s, st;
    cfg_write(8'hC4, 8'h01);
    access(1, 16'h0010, 8'h3C, rd, c, s, st);
    check("R3 internal write no strobe", s, 0);
    check("R8 internal write length", c, 2);
    access(1, 16'h00FF, 8'hC3, rd, c, s, st);
    access(0, 16'h0010, 0, rd, c, s, st);
    check("R3 internal read", rd, 8'h3C);
    check("R3 internal read no strobe", s, 0);
    check("R8 internal read length", c, 2);
    access(0, 16'h00FF, 0, rd, c, s, st);
    check("R3 top of SRAM", rd, 8'hC3);
    access(0, 16'h0100, 0, rd, c, s, st);
    check("R3 0100 external", rd, 8'h00 ^ 8'hA5);
    check("R3 0100 strobe", s, 2);
  endtask

  task automatic t_retention();
    logic [7:0] rd; int c, s, st;
    cfg_write(8'hC4, 8'h00);
    access(1, 16'h0010, 8'h77, rd, c, s, st);
    check("R11 mode 00 write goes external", s, 2);
    cfg_write(8'hC4, 8'h01);
    access(0, 16'h0010, 0, rd, c, s, st);
    check("R11 SRAM retained", rd, 8'h3C);
  endtask

  task automatic t_mode10();
    logic [7:0] rd; int c, s, st;
    cfg_write(8'hC4, 8'h02);
    access(1, 16'h0010, 8'hEE, rd, c, s, st);
    check("R4 write external", s, 2);
    access(0, 16'hFFFC, 0, rd, c, s, st);
    check("R4 FFFC external", rd, 8'hFC ^ 8'hA5);
    cfg_write(8'hC4, 8'h01);
    access(0, 16'h0010, 0, rd, c, s, st);
    check("R4 SRAM untouched", rd, 8'h3C);
  endtask

  task automatic t_mode11();
    logic [7:0] rd; int c, s, st;
    cfg_write(8'hC4, 8'h03);
    access(0, 16'h0010, 0, rd, c, s, st);
    check("R5 internal", rd, 8'h3C);
    check("R5 internal no strobe", s, 0);
    access(0, 16'hFFFB, 0, rd, c, s, st);
    check("R5 FFFB external", rd, 8'hFB ^ 8'hA5);
    check("R5 FFFB strobe", s, 2);
    lock_bits = 3'b101; swap_en = 1'b1; swap_val = 3'b010;
    access(0, 16'hFFFC, 0, rd, c, s, st);
    swap_en = 1'b0;
    check("R6 status byte", rd, 8'h05);
    check("R6 no strobe", s, 0);
    check("R8 status length", c, 2);
    access(0, 16'hFFFC, 0, rd, c, s, st);
    check("R6 status resampled", rd, 8'h02);
    access(1, 16'hFFFC, 8'hFF, rd, c, s, st);
    check("R7 FFFC write no strobe", s, 0);
    access(0, 16'hFFFC, 0, rd, c, s, st);
    check("R7 status unchanged by write", rd, 8'h02);
    access(0, 16'hFFFD, 0, rd, c, s, st);
    check("R7 FFFD reads 0", rd, 8'h00);
    check("R7 FFFD no strobe", s, 0);
    access(1, 16'hFFFF, 8'h11, rd, c, s, st);
    check("R7 FFFF write no strobe", s, 0);
    check("R8 blocked length", c, 2);
    access(0, 16'hFFFF, 0, rd, c, s, st);
    check("R7 FFFF reads 0", rd, 8'h00);
  endtask

  task automatic t_stretch();
    logic [7:0] rd; int c, s, st;
    cfg_write(8'hC5, 8'h05);
    access(0, 16'h1234, 0, rd, c, s, st);
    check("R9 stretch 5 length", c, 7);
    check("R9 stretch 5 strobe cycles", s, 7);
    check("R9 address steady", st, 1);
    check("R9 data", rd, 8'h34 ^ 8'hA5);
    access(0, 16'h0020, 0, rd, c, s, st);
    check("R8 internal ignores stretch", c, 2);
    cfg_write(8'hC5, 8'h07);
    access(1, 16'h4000, 8'h99, rd, c, s, st);
    check("R9 stretch 7 length", c, 9);
    check("R9 stretch 7 strobe cycles", s, 9);
    cfg_write(8'hC5, 8'h00);
    access(0, 16'h4000, 0, rd, c, s, st);
    check("R10 stretch update next access", c, 2);
  endtask

  task automatic t_cfg_timing();
    logic [7:0] rd; int c, s, st;
    cfg_write(8'hC4, 8'h01);
    cfg_write(8'h10, 8'h00);
    cfg_write(8'hC6, 8'h00);
    access(0, 16'h0010, 0, rd, c, s, st);
    check("R10 other address ignored", s, 0);
    check("R10 other address data", rd, 8'h3C);
    fork
      access(0, 16'h0010, 0, rd, c, s, st);
      begin
        @(negedge clk);
        @(posedge clk);
        cfg_write(8'hC4, 8'h00);
      end
    join
    check("R10 in-flight keeps internal", rd, 8'h3C);
    check("R10 in-flight no strobe", s, 0);
    access(0, 16'h0010, 0, rd, c, s, st);
    check("R10 next access external", rd, 8'h10 ^ 8'hA5);
    check("R10 next access strobe", s, 2);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode00();
        t_mode01();
        t_retention();
        t_mode10();
        t_mode11();
        t_stretch();
        t_cfg_timing();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule